// File: doc/BRIEF.md
# 8-bit Harvard single-cycle execute core

This block is the decode and execute stage of a small 8-bit Harvard processor. It finishes one instruction on every clock. Each instruction is an opcode byte with an 8-bit immediate, both fetched from a program store addressed by the 16-bit program counter. The core keeps an accumulator, two memory-address registers (a low one and a page one) and an output latch. From the three opcode fields it selects the operation, the data-memory address with the destination register, and the operand source.

Data memory is read combinationally. The core drives a 16-bit address and takes the read byte back in the same cycle. Stores raise a write strobe that the memory samples on the rising clock edge. A jump or branch sets the next program-counter value directly, with no delay slot. The program store contents and any control-register side effects are handled outside this block. Opcodes that would encode such controls are executed as no-ops.

Top module: `hv8_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter, accumulator, low address register, page register and output latch all become zero.
- R2: Opcode bits 7:5 select the operation applied to accumulator A and operand B: 000 load B, 001 A AND B, 010 A OR B, 011 A XOR B, 100 A+B modulo 256, 101 A-B modulo 256, 110 store, 111 jump/branch.
- R3: Opcode bits 1:0 select operand B: 00 the immediate, 01 the data-memory read byte, 10 the accumulator, 11 the external input port.
- R4: For non-branch opcodes, bits 4:2 (the mode) set the data address {high,low}: mode 0, 4, 5 or 6 gives {0,imm}; mode 1 gives {0,X}; mode 2 gives {Y,imm}; mode 3 or 7 gives {Y,X}. Branch opcodes always address {0,imm}.
- R5: For operations 000 to 101 the result goes to the accumulator in modes 0 to 3, to X in mode 4, to Y in mode 5, and to the output latch in modes 6 and 7. No other register changes, apart from R6.
- R6: In mode 7, every non-branch opcode except the no-op of R8 increments X modulo 256 after the access, and Y is unchanged.
- R7: A store (110) whose operand source is not 01 raises the write strobe for one cycle and writes operand B to the R4 address. In mode 4 it also copies the accumulator into X, and in mode 5 into Y. It never changes the accumulator or the output latch.
- R8: A store with operand source 01 is a no-op: no write strobe, and no register other than the program counter changes.
- R9: Every non-branch opcode advances the program counter by one, modulo 65536.
- R10: For branch opcodes, the mode selects the condition on the accumulator read as a signed byte: 0 always (far), 1 greater than zero, 2 less than zero, 3 not zero, 4 zero, 5 at least zero, 6 at most zero, 7 always (in page).
- R11: A taken branch uses operand B (R3) as the low byte of the target. Mode 0 takes the high byte from Y. Other modes keep the high byte of the program counter plus one. A branch that is not taken advances the program counter by one.
- R12: Branch opcodes write no register other than the program counter and never raise the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 8 | Opcode byte of the current instruction |
| imm_i | input | 8 | Immediate byte of the current instruction |
| in_i | input | 8 | External input port |
| rdata_i | input | 8 | Data-memory read byte for `addr_o` |
| addr_o | output | 16 | Data-memory address |
| wdata_o | output | 8 | Data-memory write byte |
| we_o | output | 1 | Data-memory write strobe |
| pc_o | output | 16 | Program counter (address of the current instruction) |
| ac_o | output | 8 | Accumulator |
| x_o | output | 8 | Low address register |
| y_o | output | 8 | Page address register |
| out_o | output | 8 | Output latch |

## Verification
Some rules hold on every cycle whatever the opcode, and the assertions cover these. The write strobe only appears for real stores. The no-op store changes nothing. Sequential opcodes step the program counter. Mode 7 bumps X without touching Y. Branches leave every data register alone. The exact values need a model, so only the bench scenarios show them: ALU results, which operand and address each field picks, the signed branch decisions, the far and in-page targets, and the page carry when the in-page branch sits at the last byte of a page. The bench compares every port with a behavioural model after every instruction.

// File: rtl/hv8_pkg.sv
// Shared encodings for the 8-bit Harvard execute core.
// Assumes the opcode layout: bits 7:5 operation, 4:2 mode, 1:0 operand source.
package hv8_pkg;
    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        GRP_LD  = 3'd0,
        GRP_AND = 3'd1,
        GRP_OR  = 3'd2,
        GRP_XOR = 3'd3,
        GRP_ADD = 3'd4,
        GRP_SUB = 3'd5,
        GRP_ST  = 3'd6,
        GRP_JMP = 3'd7
    } grp_e;

    typedef enum logic [1:0] {
        SRC_IMM = 2'd0,
        SRC_MEM = 2'd1,
        SRC_AC  = 2'd2,
        SRC_IN  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        DST_NONE = 3'd0,
        DST_AC   = 3'd1,
        DST_X    = 3'd2,
        DST_Y    = 3'd3,
        DST_OUT  = 3'd4
    } dst_e;

    typedef enum logic [1:0] {
        AM_Z_IMM = 2'd0,
        AM_Z_X   = 2'd1,
        AM_Y_IMM = 2'd2,
        AM_Y_X   = 2'd3
    } am_e;

    typedef struct packed {
        grp_e       grp;
        src_e       src;
        dst_e       dst;
        am_e        am;
        logic       x_inc;
        logic       mem_wr;
        logic       is_jmp;
        logic [2:0] cond;
    } dec_t;
endpackage

// File: rtl/hv8_decode.sv
// Opcode decoder: splits the opcode byte into operation, addressing,
// destination and source controls. Purely combinational.
// Assumes a store with the memory source is a full no-op.
module hv8_decode
    import hv8_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output dec_t            dec_o
);
    logic [2:0] mode;
    logic       jmp;
    logic       st;
    logic       nop;

    assign mode = op_i[4:2];
    assign jmp  = (op_i[7:5] == 3'b111);
    assign st   = (op_i[7:5] == 3'b110);
    assign nop  = st && (op_i[1:0] == 2'b01);

    // Build the control word from the three opcode fields.
    always_comb begin
        dec_o        = '0;
        dec_o.grp    = grp_e'(op_i[7:5]);
        dec_o.src    = src_e'(op_i[1:0]);
        dec_o.is_jmp = jmp;
        dec_o.cond   = mode;
        dec_o.mem_wr = st && !nop;
        dec_o.x_inc  = !jmp && !nop && (mode == 3'd7);
        if (jmp) begin
            dec_o.am = AM_Z_IMM;
        end else begin
            case (mode)
                3'd1:        dec_o.am = AM_Z_X;
                3'd2:        dec_o.am = AM_Y_IMM;
                3'd3, 3'd7:  dec_o.am = AM_Y_X;
                default:     dec_o.am = AM_Z_IMM;
            endcase
        end
        if (jmp || nop) begin
            dec_o.dst = DST_NONE;
        end else begin
            case (mode)
                3'd4:        dec_o.dst = DST_X;
                3'd5:        dec_o.dst = DST_Y;
                3'd6, 3'd7:  dec_o.dst = st ? DST_NONE : DST_OUT;
                default:     dec_o.dst = st ? DST_NONE : DST_AC;
            endcase
        end
    end
endmodule

// File: rtl/hv8_alu.sv
// Byte ALU: load, AND, OR, XOR, add and subtract, all modulo 2^W.
// Assumes store and branch groups ignore the result (they pass B).
module hv8_alu
    import hv8_pkg::*;
#(
    parameter int W = 8
) (
    input  grp_e         grp_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    // Select the result of the operation group.
    always_comb begin
        case (grp_i)
            GRP_AND: y_o = a_i & b_i;
            GRP_OR:  y_o = a_i | b_i;
            GRP_XOR: y_o = a_i ^ b_i;
            GRP_ADD: y_o = a_i + b_i;
            GRP_SUB: y_o = a_i - b_i;
            default: y_o = b_i;
        endcase
    end
endmodule

// File: rtl/hv8_branch.sv
// Next program counter: sequential step, far jump via the page register,
// or in-page branch on a signed test of the accumulator against zero.
// Assumes no delay slot: the target is the very next instruction.
module hv8_branch #(
    parameter int W = 8
) (
    input  logic           is_jmp_i,
    input  logic [2:0]     cond_i,
    input  logic [W-1:0]   ac_i,
    input  logic [W-1:0]   page_i,
    input  logic [W-1:0]   target_i,
    input  logic [2*W-1:0] pc_i,
    output logic [2*W-1:0] pc_nxt_o
);
    logic           neg;
    logic           zero;
    logic           taken;
    logic [2*W-1:0] pc_inc;

    assign neg    = ac_i[W-1];
    assign zero   = (ac_i == '0);
    assign pc_inc = pc_i + 1'b1;

    // Evaluate the branch condition selected by the mode field.
    always_comb begin
        case (cond_i)
            3'd1:    taken = !neg && !zero;
            3'd2:    taken = neg;
            3'd3:    taken = !zero;
            3'd4:    taken = zero;
            3'd5:    taken = !neg;
            3'd6:    taken = neg || zero;
            default: taken = 1'b1;
        endcase
    end

    // Pick the next program counter value.
    always_comb begin
        if (!is_jmp_i || !taken) begin
            pc_nxt_o = pc_inc;
        end else if (cond_i == 3'd0) begin
            pc_nxt_o = {page_i, target_i};
        end else begin
            pc_nxt_o = {pc_inc[2*W-1:W], target_i};
        end
    end
endmodule

// File: rtl/hv8_core.sv
// Single-cycle execute core of an 8-bit Harvard processor. Decodes the
// opcode, forms the data address and operand, runs the ALU or store, and
// updates the registers and program counter on each rising edge.
// Assumes data memory reads combinationally and writes on the clock edge.
module hv8_core
    import hv8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            op_i,
    input  logic [DATA_W-1:0]     imm_i,
    input  logic [DATA_W-1:0]     in_i,
    input  logic [DATA_W-1:0]     rdata_i,
    output logic [2*DATA_W-1:0]   addr_o,
    output logic [DATA_W-1:0]     wdata_o,
    output logic                  we_o,
    output logic [2*DATA_W-1:0]   pc_o,
    output logic [DATA_W-1:0]     ac_o,
    output logic [DATA_W-1:0]     x_o,
    output logic [DATA_W-1:0]     y_o,
    output logic [DATA_W-1:0]     out_o
);
    localparam int ADDR_W = 2 * DATA_W;

    dec_t              dec;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] wr_val;
    logic [ADDR_W-1:0] pc_nxt;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ac_q;
    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] y_q;
    logic [DATA_W-1:0] out_q;

    hv8_decode u_dec (
        .op_i  (op_i),
        .dec_o (dec)
    );

    // Form the data-memory address from the addressing mode.
    always_comb begin
        case (dec.am)
            AM_Z_X:   addr_o = {{DATA_W{1'b0}}, x_q};
            AM_Y_IMM: addr_o = {y_q, imm_i};
            AM_Y_X:   addr_o = {y_q, x_q};
            default:  addr_o = {{DATA_W{1'b0}}, imm_i};
        endcase
    end

    // Select the operand on the internal bus.
    always_comb begin
        case (dec.src)
            SRC_MEM: bus = rdata_i;
            SRC_AC:  bus = ac_q;
            SRC_IN:  bus = in_i;
            default: bus = imm_i;
        endcase
    end

    hv8_alu #(.W(DATA_W)) u_alu (
        .grp_i (dec.grp),
        .a_i   (ac_q),
        .b_i   (bus),
        .y_o   (alu_y)
    );

    hv8_branch #(.W(DATA_W)) u_br (
        .is_jmp_i (dec.is_jmp),
        .cond_i   (dec.cond),
        .ac_i     (ac_q),
        .page_i   (y_q),
        .target_i (bus),
        .pc_i     (pc_q),
        .pc_nxt_o (pc_nxt)
    );

    assign wr_val  = (dec.grp == GRP_ST) ? ac_q : alu_y;
    assign we_o    = dec.mem_wr;
    assign wdata_o = bus;

    // Register update: reset, program counter, destination and X step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ac_q  <= '0;
            x_q   <= '0;
            y_q   <= '0;
            out_q <= '0;
        end else begin
            pc_q <= pc_nxt;
            case (dec.dst)
                DST_AC:  ac_q  <= wr_val;
                DST_X:   x_q   <= wr_val;
                DST_Y:   y_q   <= wr_val;
                DST_OUT: out_q <= wr_val;
                default: ;
            endcase
            if (dec.x_inc) begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    assign pc_o  = pc_q;
    assign ac_o  = ac_q;
    assign x_o   = x_q;
    assign y_o   = y_q;
    assign out_o = out_q;
endmodule

// File: rtl/hv8_core_chk.sv
// Cycle-level checker for hv8_core, attached by bind. Observes only the
// ports and relates the opcode in one cycle to the state in the next.
module hv8_core_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          op_i,
    input logic                we_o,
    input logic [2*DATA_W-1:0] pc_o,
    input logic [DATA_W-1:0]   ac_o,
    input logic [DATA_W-1:0]   x_o,
    input logic [DATA_W-1:0]   y_o,
    input logic [DATA_W-1:0]   out_o
);
    logic is_br;
    logic is_st;
    logic is_nop;
    logic step_x;

    assign is_br  = (op_i[7:5] == 3'b111);
    assign is_st  = (op_i[7:5] == 3'b110);
    assign is_nop = is_st && (op_i[1:0] == 2'b01);
    assign step_x = !is_br && !is_nop && (op_i[4:2] == 3'b111);

    AST_STROBE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (is_st && !is_nop)); // R7

    AST_NOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop |=> ($stable(ac_o) && $stable(x_o) && $stable(y_o) && $stable(out_o))); // R8

    AST_NOOP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop |-> !we_o); // R8

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !is_br |=> (pc_o == $past(pc_o) + 1'b1)); // R9

    AST_X_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
        step_x |=> ((x_o == $past(x_o) + 1'b1) && $stable(y_o))); // R6

    AST_BRANCH_REGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        is_br |=> ($stable(ac_o) && $stable(x_o) && $stable(y_o) && $stable(out_o))); // R12

    AST_BRANCH_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        is_br |-> !we_o); // R12

    AST_STORE_KEEPS_AC: assert property (@(posedge clk) disable iff (!rst_n)
        is_st |=> ($stable(ac_o) && $stable(out_o))); // R7
endmodule

bind hv8_core hv8_core_chk #(.DATA_W(DATA_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .we_o  (we_o),
    .pc_o  (pc_o),
    .ac_o  (ac_o),
    .x_o   (x_o),
    .y_o   (y_o),
    .out_o (out_o)
);

// File: tb/hv8_core_tb_top.sv
`timescale 1ns/1ps
// Bench for hv8_core: behavioural reference model, compared every cycle.
module hv8_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_i = 8'h02;
    logic [7:0]  imm_i = 8'h00;
    logic [7:0]  in_i = 8'h00;
    logic [7:0]  rdata_i;
    logic [15:0] addr_o;
    logic [7:0]  wdata_o;
    logic        we_o;
    logic [15:0] pc_o;
    logic [7:0]  ac_o, x_o, y_o, out_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_pc;
    logic [7:0]  m_ac, m_x, m_y, m_out;

    always #2.5 clk = ~clk;

    // Memory model: read byte is a fixed function of the address.
    function automatic logic [7:0] fmem(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'hA5;
    endfunction

    assign rdata_i = fmem(addr_o);

    hv8_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i), .in_i(in_i),
        .rdata_i(rdata_i), .addr_o(addr_o), .wdata_o(wdata_o), .we_o(we_o),
        .pc_o(pc_o), .ac_o(ac_o), .x_o(x_o), .y_o(y_o), .out_o(out_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (op %h)", tag, what, act, exp, op_i);
        end
    endtask

    task automatic chk_regs(input string tpc, input string tac, input string tx,
                            input string tr);
        chk(tpc, "pc", pc_o, m_pc);
        chk(tac, "ac", {8'h00, ac_o}, {8'h00, m_ac});
        chk(tx, "x", {8'h00, x_o}, {8'h00, m_x});
        chk(tr, "y", {8'h00, y_o}, {8'h00, m_y});
        chk(tr, "out", {8'h00, out_o}, {8'h00, m_out});
    endtask

    // Execute one instruction on the DUT and on the model, then compare.
    task automatic run(input logic [7:0] o, input logic [7:0] n, input logic [7:0] din);
        logic [2:0]  g, md;
        logic [1:0]  bs;
        logic [15:0] ea, pcn;
        logic [7:0]  b, r;
        logic        br, st, nop, we, tk;
        string       tr, tac, tx, tpc;
        g = o[7:5]; md = o[4:2]; bs = o[1:0];
        br = (g == 3'd7); st = (g == 3'd6); nop = st && (bs == 2'd1);
        @(negedge clk);
        rst_n = 1'b1; op_i = o; imm_i = n; in_i = din;
        #1;
        if (br) ea = {8'h00, n};
        else case (md)
            3'd1:       ea = {8'h00, m_x};
            3'd2:       ea = {m_y, n};
            3'd3, 3'd7: ea = {m_y, m_x};
            default:    ea = {8'h00, n};
        endcase
        case (bs)
            2'd0: b = n;
            2'd1: b = fmem(ea);
            2'd2: b = m_ac;
            default: b = din;
        endcase
        we = st && !nop;
        chk(nop ? "R8" : (br ? "R12" : "R7"), "we", {15'd0, we_o}, {15'd0, we});
        if (we) chk("R3", "wdata", {8'h00, wdata_o}, {8'h00, b});
        if (we || bs == 2'd1) chk("R4", "addr", addr_o, ea);
        pcn = m_pc + 16'd1;
        tk = 1'b0;
        if (br) begin
            case (md)
                3'd1: tk = $signed(m_ac) > 0;
                3'd2: tk = $signed(m_ac) < 0;
                3'd3: tk = m_ac != 0;
                3'd4: tk = m_ac == 0;
                3'd5: tk = $signed(m_ac) >= 0;
                3'd6: tk = $signed(m_ac) <= 0;
                default: tk = 1'b1;
            endcase
            if (!tk) m_pc = pcn;
            else if (md == 3'd0) m_pc = {m_y, b};
            else m_pc = {pcn[15:8], b};
        end else begin
            m_pc = pcn;
            if (st) begin
                if (!nop) begin
                    if (md == 3'd4) m_x = m_ac;
                    if (md == 3'd5) m_y = m_ac;
                    if (md == 3'd7) m_x = m_x + 8'd1;
                end
            end else begin
                case (g)
                    3'd1: r = m_ac & b;
                    3'd2: r = m_ac | b;
                    3'd3: r = m_ac ^ b;
                    3'd4: r = m_ac + b;
                    3'd5: r = m_ac - b;
                    default: r = b;
                endcase
                case (md)
                    3'd4: m_x = r;
                    3'd5: m_y = r;
                    3'd6: m_out = r;
                    3'd7: begin m_out = r; m_x = m_x + 8'd1; end
                    default: m_ac = r;
                endcase
            end
        end
        tr  = br ? "R12" : (nop ? "R8" : (st ? "R7" : "R5"));
        tac = (!br && !st && md < 3'd4) ? "R2" : tr;
        tx  = (!br && !nop && md == 3'd7) ? "R6" : tr;
        tpc = br ? ((md == 3'd0 || md == 3'd7) ? "R11" : "R10") : "R9";
        @(posedge clk);
        #1;
        chk_regs(tpc, tac, tx, tr);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_pc = '0; m_ac = '0; m_x = '0; m_y = '0; m_out = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_regs("R1", "R1", "R1", "R1");
        // R2 R3: operations and sources
        run(8'h00, 8'h3C, 8'h00);       // ld nn
        run(8'h20, 8'h0F, 8'h00);       // and nn -> 0C
        run(8'h40, 8'hA0, 8'h00);       // or nn
        run(8'h60, 8'hFF, 8'h00);       // xor nn
        run(8'h80, 8'hC0, 8'h00);       // add, wraps
        run(8'hA0, 8'hF0, 8'h00);       // sub, wraps
        run(8'h03, 8'h00, 8'h81);       // ld in
        run(8'h82, 8'h00, 8'h00);       // add ac
        run(8'h01, 8'h44, 8'h00);       // ld [nn]
        // R4 R5: modes and destinations
        run(8'h14, 8'h12, 8'h00);       // ld nn -> Y
        run(8'h10, 8'hFE, 8'h00);       // ld nn -> X
        run(8'h05, 8'h00, 8'h00);       // ld [X]
        run(8'h09, 8'h77, 8'h00);       // ld [Y,nn]
        run(8'h0D, 8'h00, 8'h00);       // ld [Y,X]
        run(8'h18, 8'h5A, 8'h00);       // ld nn -> OUT
        // R6: mode 7 with X wrap
        run(8'h5D, 8'h00, 8'h00);       // or [Y,X] -> OUT, X++
        run(8'h5D, 8'h00, 8'h00);       // X FF -> 00
        run(8'hDE, 8'h00, 8'h00);       // st ac [Y,X], X++
        // R7 R8: stores and no-ops
        run(8'hC0, 8'h99, 8'h00);
        run(8'hC3, 8'h10, 8'h6B);
        run(8'hD2, 8'h20, 8'h00);       // st ac, X <- ac
        run(8'hD6, 8'h21, 8'h00);       // st ac, Y <- ac
        run(8'hC1, 8'h30, 8'h00);       // no-op
        run(8'hDD, 8'h00, 8'h00);       // no-op, no X++
        // R10 R11: branches, page carry
        run(8'h14, 8'h12, 8'h00);
        run(8'hE0, 8'hFF, 8'h00);       // far to 12FF
        run(8'hFC, 8'h40, 8'h00);       // in page -> 1340
        run(8'h00, 8'h80, 8'h00);
        run(8'hE4, 8'h10, 8'h00);       // gt not taken
        run(8'hE8, 8'h10, 8'h00);       // lt taken
        run(8'hF8, 8'h20, 8'h00);       // le taken
        run(8'h00, 8'h00, 8'h00);
        run(8'hF0, 8'h30, 8'h00);       // eq taken
        run(8'hEC, 8'h30, 8'h00);       // ne not taken
        run(8'hF4, 8'h40, 8'h00);       // ge taken
        run(8'hFE, 8'h00, 8'h00);       // bra ac
        run(8'hFD, 8'h55, 8'h00);       // bra [nn]
        run(8'hE1, 8'h56, 8'h00);       // far [nn]
        run(8'hE2, 8'h00, 8'h00);       // far ac
        // mixed random stream
        for (int i = 0; i < 4000; i++) begin
            run(8'($urandom), 8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule